// File: doc/BRIEF.md
# Supply Switchover and Low-Line Monitor

This block is the digital decision core of a RAM power path. Each sample gives the main supply and the backup cell voltage as unsigned millivolt codes. From them the block decides whether the RAM rail is fed from the main supply or from the backup cell. It also gives an early low-line warning for a non-maskable interrupt. Finally it drives a "supply under reset threshold" flag, which a reset sequencer consumes.

The block holds three comparator states, each with hysteresis:
- supply against the reset threshold;
- supply against the warning threshold, which sits a fixed offset above the reset threshold;
- supply against the battery, with the release point raised by a fixed margin.

Backup mode needs both the reset condition and the battery condition at once. A battery that sits above a healthy supply therefore never causes a switchover. The reset threshold is chosen by a two-bit setting. That setting is captured only while the block is held in reset.

Top module: `pwr_path_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs are `bkup_sel`=1, `lowline_n`=0 and `below_rst`=1. All three comparator states start in their "low" condition.
- R2: `thr_cfg` selects the reset threshold: 0→4675 mV, 1→4575 mV, 2→4425 mV, 3→4675 mV. It is sampled only on clock edges with `rst_n` low. Changes while the block is running have no effect.
- R3: `below_rst` sets on a valid sample with supply < threshold. Once set, it clears only on a valid sample with supply ≥ threshold + 13.
- R4: The warning comparator sets on a valid sample with supply < threshold + 52. Once set, it clears only on a valid sample with supply ≥ threshold + 65. `lowline_n` is 0 whenever this comparator is set.
- R5: The supply counts as under the battery once a valid sample has supply < battery. It counts as over the battery again only when supply ≥ battery + 50.
- R6: `bkup_sel` is 1 exactly when, after the latest valid sample, the reset comparator and the battery comparator are both set.
- R7: If the battery is above the supply while the supply is at or above the reset threshold, the block neither selects backup nor raises `below_rst`.
- R8: `lowline_n` is 0 whenever `bkup_sel` is 1.
- R9: The outputs change only on the clock edge that samples `smp_vld`=1, and they show the new sample from the following cycle on. When `smp_vld` is 0 they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; threshold setting is captured while low |
| thr_cfg | input | 2 | Reset-threshold selection code |
| smp_vld | input | 1 | Sample strobe; voltages are taken when high |
| vsup_mv | input | 13 | Main supply voltage, millivolts, unsigned |
| vbat_mv | input | 13 | Backup cell voltage, millivolts, unsigned |
| bkup_sel | output | 1 | 1 selects the backup cell for the RAM rail |
| lowline_n | output | 1 | Active-low early power-fail warning |
| below_rst | output | 1 | Supply is under the reset threshold |

## Verification
On every cycle, the assertions check the relations between the outputs:
- backup implies the reset flag;
- backup forces the warning;
- the reset flag forces the warning;
- nothing moves without a sample strobe;
- the captured threshold is always one of the legal values.

The exact trip and release points of each hysteresis band can only be shown by the bench's scenarios. The same holds for the asymmetric battery margin, the threshold encoding, and the setting being ignored after reset. These scenarios step the supply across each edge by one millivolt and compare against a behavioural model on every clock.

// File: rtl/pwr_path_pkg.sv
package pwr_path_pkg;

    typedef struct packed {
        logic blw;    // supply under reset threshold
        logic llw;    // supply under warning threshold
        logic batlo;  // supply under battery
        logic bkup;   // backup selected
        logic lln;    // registered active-low warning
    } mon_state_t;

    localparam mon_state_t MON_RST = '{blw: 1'b1, llw: 1'b1, batlo: 1'b1,
                                       bkup: 1'b1, lln: 1'b0};

endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
    parameter int unsigned CW = 14
) (
    input  logic [CW-1:0] val,
    input  logic [CW-1:0] trip,
    input  logic [CW-1:0] rel,
    input  logic          cur_low,
    output logic          nxt_low
);
    // In the low state the release point applies, otherwise the trip point.
    always_comb begin
        if (cur_low) nxt_low = (val < rel);
        else         nxt_low = (val < trip);
    end
endmodule

// File: rtl/thr_sel.sv
module thr_sel #(
    parameter int unsigned VW     = 13,
    parameter int unsigned THR_HI = 4675,
    parameter int unsigned THR_MD = 4575,
    parameter int unsigned THR_LO = 4425
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg,
    output logic [VW-1:0] thr
);
    logic [1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) cfg_d = cfg;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    always_comb begin
        case (cfg_q)
            2'd1:    thr = VW'(THR_MD);
            2'd2:    thr = VW'(THR_LO);
            default: thr = VW'(THR_HI);
        endcase
    end

    // R2
    thr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == VW'(THR_HI)) || (thr == VW'(THR_MD)) || (thr == VW'(THR_LO)));
endmodule

// File: rtl/pwr_path_monitor.sv
module pwr_path_monitor
    import pwr_path_pkg::*;
#(
    parameter int unsigned VW      = 13,
    parameter int unsigned THR_HI  = 4675,
    parameter int unsigned THR_MD  = 4575,
    parameter int unsigned THR_LO  = 4425,
    parameter int unsigned RST_HYS = 13,
    parameter int unsigned LL_OFS  = 52,
    parameter int unsigned LL_HYS  = 13,
    parameter int unsigned BAT_HYS = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    thr_cfg,
    input  logic          smp_vld,
    input  logic [VW-1:0] vsup_mv,
    input  logic [VW-1:0] vbat_mv,
    output logic          bkup_sel,
    output logic          lowline_n,
    output logic          below_rst
);
    localparam int unsigned CW = VW + 1;

    logic [VW-1:0] thr;
    logic [CW-1:0] sup_w, rst_trip, rst_rel, ll_trip, ll_rel, bat_trip, bat_rel;
    logic          blw_n, llw_n, bat_n;
    mon_state_t    st_d, st_q;

    thr_sel #(.VW(VW), .THR_HI(THR_HI), .THR_MD(THR_MD), .THR_LO(THR_LO)) i_thr (
        .clk(clk), .rst_n(rst_n), .cfg(thr_cfg), .thr(thr)
    );

    // Extended width so offsets on a full-scale code cannot wrap.
    always_comb begin
        sup_w    = {1'b0, vsup_mv};
        rst_trip = {1'b0, thr};
        rst_rel  = rst_trip + CW'(RST_HYS);
        ll_trip  = rst_trip + CW'(LL_OFS);
        ll_rel   = ll_trip + CW'(LL_HYS);
        bat_trip = {1'b0, vbat_mv};
        bat_rel  = bat_trip + CW'(BAT_HYS);
    end

    hyst_cmp #(.CW(CW)) i_rst_cmp (
        .val(sup_w), .trip(rst_trip), .rel(rst_rel), .cur_low(st_q.blw), .nxt_low(blw_n)
    );
    hyst_cmp #(.CW(CW)) i_ll_cmp (
        .val(sup_w), .trip(ll_trip), .rel(ll_rel), .cur_low(st_q.llw), .nxt_low(llw_n)
    );
    hyst_cmp #(.CW(CW)) i_bat_cmp (
        .val(sup_w), .trip(bat_trip), .rel(bat_rel), .cur_low(st_q.batlo), .nxt_low(bat_n)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = MON_RST;
        end else if (smp_vld) begin
            st_d.blw   = blw_n;
            st_d.llw   = llw_n;
            st_d.batlo = bat_n;
            st_d.bkup  = blw_n & bat_n;
            st_d.lln   = ~(llw_n | (blw_n & bat_n));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bkup_sel  = st_q.bkup;
    assign lowline_n = st_q.lln;
    assign below_rst = st_q.blw;

    // R6
    bkup_needs_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkup_sel |-> below_rst);
    // R8
    bkup_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkup_sel |-> !lowline_n);
    // R4
    rst_implies_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        below_rst |-> !lowline_n);
    // R9
    hold_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && $past(rst_n)) |=> ($stable(bkup_sel) && $stable(lowline_n) && $stable(below_rst)));
endmodule

// File: tb/test_pwr_path_monitor.sv
module test_pwr_path_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  thr_cfg = 2'd0;
    logic        smp_vld = 1'b0;
    logic [12:0] vsup_mv = 13'd0;
    logic [12:0] vbat_mv = 13'd0;
    logic        bkup_sel, lowline_n, below_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference
    int m_thr = 4675;
    bit m_blw = 1, m_llw = 1, m_bat = 1, m_bk = 1;

    always #5 clk = ~clk;

    pwr_path_monitor i_pwr_path_monitor (
        .clk(clk), .rst_n(rst_n), .thr_cfg(thr_cfg), .smp_vld(smp_vld),
        .vsup_mv(vsup_mv), .vbat_mv(vbat_mv),
        .bkup_sel(bkup_sel), .lowline_n(lowline_n), .below_rst(below_rst)
    );

    always @(posedge clk) begin
        int s, b;
        s = int'(vsup_mv);
        b = int'(vbat_mv);
        if (!rst_n) begin
            case (thr_cfg)
                2'd1: m_thr = 4575;
                2'd2: m_thr = 4425;
                default: m_thr = 4675;
            endcase
            m_blw = 1; m_llw = 1; m_bat = 1; m_bk = 1;
            started = 1;
        end else if (smp_vld) begin
            m_blw = m_blw ? (s < m_thr + 13) : (s < m_thr);
            m_llw = m_llw ? (s < m_thr + 65) : (s < m_thr + 52);
            m_bat = m_bat ? (s < b + 50) : (s < b);
            m_bk  = m_blw && m_bat;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (started && !done) begin
            chk("R6 model bkup_sel", bkup_sel, m_bk);
            chk("R4 model lowline_n", lowline_n, !(m_llw || m_bk));
            chk("R3 model below_rst", below_rst, m_blw);
        end
        if (cyc > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_reset(logic [1:0] cfg);
        @(negedge clk);
        rst_n = 1'b0;
        smp_vld = 1'b0;
        thr_cfg = cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic smp(int s, int b);
        @(negedge clk);
        vsup_mv = 13'(s);
        vbat_mv = 13'(b);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic outs(string req, logic ebk, logic elln, logic eblw);
        chk({req, " bkup_sel"}, bkup_sel, ebk);
        chk({req, " lowline_n"}, lowline_n, elln);
        chk({req, " below_rst"}, below_rst, eblw);
    endtask

    initial begin
        do_reset(2'd0);
        outs("R1 reset", 1'b1, 1'b0, 1'b1);

        smp(5000, 3000);
        outs("R3 healthy", 1'b0, 1'b1, 1'b0);

        // R9: no strobe, outputs hold
        @(negedge clk);
        vsup_mv = 13'd4000;
        repeat (3) @(negedge clk);
        outs("R9 hold", 1'b0, 1'b1, 1'b0);

        // R4 warning band, threshold 4675
        smp(4728, 3000); chk("R4 above trip", lowline_n, 1'b1);
        smp(4726, 3000); chk("R4 trip", lowline_n, 1'b0);
        smp(4739, 3000); chk("R4 hysteresis", lowline_n, 1'b0);
        smp(4740, 3000); chk("R4 release", lowline_n, 1'b1);

        // R3 reset band
        smp(4675, 3000); chk("R3 at threshold", below_rst, 1'b0);
        smp(4674, 3000); outs("R3 trip", 1'b0, 1'b0, 1'b1);
        smp(4687, 3000); chk("R3 hysteresis", below_rst, 1'b1);
        smp(4688, 3000); chk("R3 release", below_rst, 1'b0);

        // R7 battery above healthy supply
        smp(4700, 5000); outs("R7 battery high", 1'b0, 1'b0, 1'b0);

        // R6/R8 both conditions
        smp(4600, 5000); outs("R6 R8 backup", 1'b1, 1'b0, 1'b1);

        // R5 asymmetric battery margin
        smp(2990, 3000); chk("R5 under battery", bkup_sel, 1'b1);
        smp(3049, 3000); chk("R5 margin holds", bkup_sel, 1'b1);
        smp(3050, 3000); outs("R5 release", 1'b0, 1'b0, 1'b1);
        smp(3020, 3000); chk("R5 no retrip above battery", bkup_sel, 1'b0);
        smp(2999, 3000); chk("R5 retrip", bkup_sel, 1'b1);

        // R2 threshold encoding and capture only in reset
        do_reset(2'd2);
        smp(4500, 3000); outs("R2 code2", 1'b0, 1'b1, 1'b0);
        thr_cfg = 2'd1;
        smp(4430, 3000); chk("R2 cfg ignored while running", below_rst, 1'b0);
        smp(4424, 3000); chk("R2 code2 trip", below_rst, 1'b1);

        do_reset(2'd3);
        smp(4687, 3000); chk("R2 code3", below_rst, 1'b1);
        smp(4688, 3000); chk("R2 code3 release", below_rst, 1'b0);

        do_reset(2'd1);
        smp(4587, 3000); chk("R2 code1", below_rst, 1'b1);
        smp(4588, 3000); chk("R2 code1 release", below_rst, 1'b0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule